// File: doc/BRIEF.md
# Multi-Channel DAC Command Decoder

This block is the digital front end of a serially programmed multi-channel digital-to-analog converter. A host drives it as an SPI slave: it pulls the select line low, clocks in a 24-bit command frame most significant bit first, and releases select. When select rises, the block decodes the frame, provided exactly 24 bits arrived.

Each channel holds two codes. The input code is a staging value. The active code is what the converter would output. Each channel also has a power-down flag, and the whole device has one reference-select flag. Commands can stage a code, promote staged codes, power channels down, and choose the reference.

The serial pins are sampled by the system clock after a synchronizer. The channel count (2, 4 or 8) and the code resolution (8, 10 or 12 bits) are parameters. The active codes, the power-down flags and the reference choice are presented as parallel outputs.

Top module: `dac_cmd_decoder`

## Requirements
- R1: Bits are taken on each rising edge of `sclk_i` while `csn_i` is low, most significant bit first. When `csn_i` rises, the frame is acted on only if exactly 24 bits were taken since `csn_i` fell. A shorter or longer burst changes nothing.
- R2: Frame bits 23:20 hold the command and bits 19:16 hold the channel number. The code occupies bits 15 down to 16-RES. The bits below the code have no effect. Channel i's active code appears on `active_code_o[i*RES +: RES]`.
- R3: Command 0x0 loads the addressed channel's input code and leaves every active code unchanged.
- R4: Command 0x1 copies the addressed channel's input code into its active code.
- R5: Command 0x2 loads the addressed channel's input code. In the same step, every channel's active code takes its input code, and the addressed channel takes the new value.
- R6: Command 0x3 loads the frame's code into both the input code and the active code of the addressed channel.
- R7: Command 0x4 sets the addressed channel's bit of `pd_o`. Command 0x5 sets every bit of `pd_o`.
- R8: Commands 0x0, 0x1 and 0x3 clear the addressed channel's `pd_o` bit. Command 0x2 clears all `pd_o` bits.
- R9: Command 0x7 drives `ext_ref_o` to 1 (external reference). Command 0x6 drives it to 0 (internal reference).
- R10: Commands 0x8 to 0xF change nothing. Commands 0x0 to 0x4 carrying a channel number at or above NUM_CH change nothing.
- R11: After reset, all input and active codes are zero, all `pd_o` bits are clear, and `ext_ref_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data from the host |
| active_code_o | output | NUM_CH*RES | Active codes of all channels, channel 0 in the low bits |
| pd_o | output | NUM_CH | Per-channel power-down flags |
| ext_ref_o | output | 1 | 1 selects the external reference |

## Verification
Command 0x2 performs two functions in the same cycle: it writes one channel's input code and promotes every channel's input code to its active code. The addressed channel must pick up the freshly written value, not its stale input. The other channels must take whatever they held staged.

The bench provokes this by staging distinct codes on several channels with command 0x0 and then issuing 0x2 to a channel whose staged code differs from the new one. It judges the result against a behavioural model that applies the write before the promotion. The model is compared with all outputs on every clock outside the short decode window.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int FRAME_W = 24;

  typedef enum logic [3:0] {
    CMD_WR_IN      = 4'h0,
    CMD_UPD        = 4'h1,
    CMD_WR_UPD_ALL = 4'h2,
    CMD_WR_UPD     = 4'h3,
    CMD_PD_CH      = 4'h4,
    CMD_PD_ALL     = 4'h5,
    CMD_REF_INT    = 4'h6,
    CMD_REF_EXT    = 4'h7
  } cmd_e;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [3:0]  addr;
    logic [15:0] payload;
  } frame_t;
endpackage

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sclk_i,
  input  logic   csn_i,
  input  logic   mosi_i,
  output frame_t frame_o,
  output logic   frame_vld_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [SYNC_STAGES-1:0] sclk_sync, csn_sync, mosi_sync;
  logic sclk_s, csn_s, mosi_s, sclk_d, csn_d;
  logic sclk_rise, cs_rise;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   bit_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sync <= '0;
      csn_sync  <= '1;
      mosi_sync <= '0;
      sclk_d    <= 1'b0;
      csn_d     <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      csn_sync  <= {csn_sync[SYNC_STAGES-2:0], csn_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      sclk_d    <= sclk_s;
      csn_d     <= csn_s;
    end
  end

  assign sclk_s    = sclk_sync[SYNC_STAGES-1];
  assign csn_s     = csn_sync[SYNC_STAGES-1];
  assign mosi_s    = mosi_sync[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = csn_s & ~csn_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q     <= '0;
      bit_cnt_q   <= '0;
      frame_vld_o <= 1'b0;
    end else if (cs_rise) begin
      frame_vld_o <= (bit_cnt_q == CNT_W'(FRAME_W));
      bit_cnt_q   <= '0;
    end else begin
      frame_vld_o <= 1'b0;
      if (!csn_s && sclk_rise) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], mosi_s};
        if (bit_cnt_q != '1) bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  assign frame_o = frame_t'(shreg_q);

  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o);
  a_r1_exact_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |-> $past(bit_cnt_q) == CNT_W'(FRAME_W));
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES    = 12
) (
  input  logic              frame_vld_i,
  input  frame_t            frame_i,
  output logic [NUM_CH-1:0] in_we_o,
  output logic [NUM_CH-1:0] act_new_o,
  output logic [NUM_CH-1:0] act_cp_o,
  output logic [NUM_CH-1:0] pd_set_o,
  output logic [NUM_CH-1:0] pd_clr_o,
  output logic [RES-1:0]    code_o,
  output logic              ref_int_o,
  output logic              ref_ext_o
);
  logic [NUM_CH-1:0] sel;
  logic addr_ok;
  cmd_e cmd;
  logic unused_lo;

  assign cmd       = cmd_e'(frame_i.cmd);
  assign code_o    = frame_i.payload[15 -: RES];
  assign unused_lo = ^frame_i.payload[15-RES:0];
  assign addr_ok   = (frame_i.addr < 4'(NUM_CH));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel[i] = (frame_i.addr == 4'(i));
  end

  always_comb begin
    in_we_o   = '0;
    act_new_o = '0;
    act_cp_o  = '0;
    pd_set_o  = '0;
    pd_clr_o  = '0;
    ref_int_o = 1'b0;
    ref_ext_o = 1'b0;
    if (frame_vld_i) begin
      case (cmd)
        CMD_WR_IN: begin
          in_we_o  = sel;
          pd_clr_o = sel;
        end
        CMD_UPD: begin
          act_cp_o = sel;
          pd_clr_o = sel;
        end
        CMD_WR_UPD_ALL: if (addr_ok) begin
          in_we_o   = sel;
          act_new_o = sel;
          act_cp_o  = ~sel;
          pd_clr_o  = '1;
        end
        CMD_WR_UPD: begin
          in_we_o   = sel;
          act_new_o = sel;
          pd_clr_o  = sel;
        end
        CMD_PD_CH:   pd_set_o  = sel;
        CMD_PD_ALL:  pd_set_o  = '1;
        CMD_REF_INT: ref_int_o = 1'b1;
        CMD_REF_EXT: ref_ext_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot #(
  parameter int RES = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_we_i,
  input  logic           act_new_i,
  input  logic           act_cp_i,
  input  logic           pd_set_i,
  input  logic           pd_clr_i,
  input  logic [RES-1:0] code_i,
  output logic [RES-1:0] act_o,
  output logic           pd_o
);
  logic [RES-1:0] in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      act_o <= '0;
      pd_o  <= 1'b0;
    end else begin
      if (in_we_i) in_q <= code_i;
      // new code wins over the staged one when both are requested
      if (act_new_i)     act_o <= code_i;
      else if (act_cp_i) act_o <= in_q;
      if (pd_set_i)      pd_o  <= 1'b1;
      else if (pd_clr_i) pd_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int RES         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  csn_i,
  input  logic                  mosi_i,
  output logic [NUM_CH*RES-1:0] active_code_o,
  output logic [NUM_CH-1:0]     pd_o,
  output logic                  ext_ref_o
);
  frame_t            frm;
  logic              frm_vld;
  logic [NUM_CH-1:0] in_we, act_new, act_cp, pd_set, pd_clr;
  logic [RES-1:0]    code;
  logic              ref_int, ref_ext;

  dac_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .sclk_i, .csn_i, .mosi_i,
    .frame_o(frm), .frame_vld_o(frm_vld)
  );

  dac_cmd_decode #(.NUM_CH(NUM_CH), .RES(RES)) u_dec (
    .frame_vld_i(frm_vld), .frame_i(frm),
    .in_we_o(in_we), .act_new_o(act_new), .act_cp_o(act_cp),
    .pd_set_o(pd_set), .pd_clr_o(pd_clr), .code_o(code),
    .ref_int_o(ref_int), .ref_ext_o(ref_ext)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dac_chan_slot #(.RES(RES)) u_slot (
      .clk_i, .rst_ni,
      .in_we_i(in_we[i]), .act_new_i(act_new[i]), .act_cp_i(act_cp[i]),
      .pd_set_i(pd_set[i]), .pd_clr_i(pd_clr[i]), .code_i(code),
      .act_o(active_code_o[i*RES +: RES]), .pd_o(pd_o[i])
    );

    a_r6_wr_upd_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld && frm.cmd == CMD_WR_UPD && frm.addr == 4'(i))
      |=> active_code_o[i*RES +: RES] == $past(frm.payload[15 -: RES]));
    a_r8_upd_all_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld && frm.cmd == CMD_WR_UPD_ALL && frm.addr < 4'(NUM_CH))
      |=> !pd_o[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ext_ref_o <= 1'b0;
    else if (ref_ext) ext_ref_o <= 1'b1;
    else if (ref_int) ext_ref_o <= 1'b0;
  end

  a_r3_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld && frm.cmd == CMD_WR_IN) |=> $stable(active_code_o));
  a_r7_pd_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld && frm.cmd == CMD_PD_ALL) |=> &pd_o);
  a_r9_ref_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld && frm.cmd == CMD_REF_EXT) |=> ext_ref_o);
  a_r9_ref_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld && frm.cmd == CMD_REF_INT) |=> !ext_ref_o);
  a_r10_bad_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld && frm.cmd[3])
    |=> $stable(active_code_o) && $stable(pd_o) && $stable(ext_ref_o));
  a_r10_bad_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld && frm.cmd <= 4'h4 && frm.addr >= 4'(NUM_CH))
    |=> $stable(active_code_o) && $stable(pd_o));
endmodule

// File: tb/dac_cmd_decoder_tb_top.sv
module dac_cmd_decoder_tb_top;
  localparam int NCH = 4;
  localparam int RES = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic [NCH*RES-1:0] act_code;
  logic [NCH-1:0] pd;
  logic ext_ref;

  int checks = 0;
  int errors = 0;
  bit busy = 1'b1;

  int in_m[NCH];
  int act_m[NCH];
  bit pd_m[NCH];
  bit ext_m = 1'b0;

  always #2 clk = ~clk;

  dac_cmd_decoder #(.NUM_CH(NCH), .RES(RES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .active_code_o(act_code), .pd_o(pd), .ext_ref_o(ext_ref)
  );

  function automatic int code_of(int ch);
    return int'(act_code[ch*RES +: RES]);
  endfunction

  function automatic logic [23:0] frm(int cmd, int addr, int code);
    return {4'(cmd), 4'(addr), 10'(code), 6'b0};
  endfunction

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // behavioural model of one decoded frame
  task automatic model_apply(logic [23:0] f);
    int cmd = int'(f[23:20]);
    int a = int'(f[19:16]);
    int c = int'(f[15:6]);
    if (cmd <= 4 && a >= NCH) return;
    case (cmd)
      0: begin in_m[a] = c; pd_m[a] = 0; end
      1: begin act_m[a] = in_m[a]; pd_m[a] = 0; end
      2: begin
        in_m[a] = c;
        for (int k = 0; k < NCH; k++) begin act_m[k] = in_m[k]; pd_m[k] = 0; end
      end
      3: begin in_m[a] = c; act_m[a] = c; pd_m[a] = 0; end
      4: pd_m[a] = 1;
      5: for (int k = 0; k < NCH; k++) pd_m[k] = 1;
      6: ext_m = 0;
      7: ext_m = 1;
      default: ;
    endcase
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    csn = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
    end
    sclk = 1'b0;
    wait_clk(4);
    busy = 1'b1;
    csn = 1'b1;
    wait_clk(8);
    if (n == 24) model_apply(v[23:0]);
    busy = 1'b0;
    wait_clk(2);
  endtask

  task automatic send(int cmd, int addr, int code);
    send_bits({8'b0, frm(cmd, addr, code)}, 24);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !busy) begin
      for (int k = 0; k < NCH; k++) begin
        checks++;
        if (code_of(k) != act_m[k]) begin
          errors++;
          $display("FAIL R2 model ch%0d code actual=%0h expected=%0h", k, code_of(k), act_m[k]);
        end
        checks++;
        if (pd[k] != pd_m[k]) begin
          errors++;
          $display("FAIL R7 model ch%0d pd actual=%0b expected=%0b", k, pd[k], pd_m[k]);
        end
      end
      checks++;
      if (ext_ref != ext_m) begin
        errors++;
        $display("FAIL R9 model ext actual=%0b expected=%0b", ext_ref, ext_m);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin in_m[k] = 0; act_m[k] = 0; pd_m[k] = 0; end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    busy = 1'b0;
    // R11 reset state
    chk("R11 codes", int'(act_code), 0);
    chk("R11 pd", int'(pd), 0);
    chk("R11 ext", int'(ext_ref), 0);

    // R3 write input only
    send(0, 1, 'h2AB);
    chk("R3 ch1 active unchanged", code_of(1), 0);
    // R4 copy staged to active
    send(1, 1, 'h000);
    chk("R4 ch1 promoted", code_of(1), 'h2AB);

    // R2 don't-care low bits set
    send_bits({8'b0, 4'h3, 4'h2, 10'h155, 6'h3F}, 24);
    chk("R2 low bits ignored", code_of(2), 'h155);
    chk("R6 ch2 direct", code_of(2), 'h155);

    // R5 write and promote all in the same step
    send(0, 0, 'h011);
    send(0, 3, 'h033);
    send(0, 1, 'h100);
    send(2, 1, 'h3FF);
    chk("R5 ch0", code_of(0), 'h011);
    chk("R5 ch1 new value", code_of(1), 'h3FF);
    chk("R5 ch2", code_of(2), 'h155);
    chk("R5 ch3", code_of(3), 'h033);

    // R7 power-down
    send(4, 2, 0);
    chk("R7 ch2 down", int'(pd), 'b0100);
    send(5, 0, 0);
    chk("R7 all down", int'(pd), 'b1111);

    // R8 wake-up
    send(3, 0, 'h0AA);
    chk("R8 ch0 woken", int'(pd), 'b1110);
    send(0, 1, 'h005);
    chk("R8 write wakes ch1", int'(pd), 'b1100);
    send(2, 3, 'h0CC);
    chk("R8 update-all wakes all", int'(pd), 'b0000);

    // R9 reference
    send(7, 0, 0);
    chk("R9 external", int'(ext_ref), 1);
    send(6, 0, 0);
    chk("R9 internal", int'(ext_ref), 0);
    send(7, 0, 0);

    // R10 ignored commands and addresses
    send(4, 1, 0);
    send(9, 0, 'h3FF);
    send(15, 1, 'h123);
    chk("R10 bad cmd codes", int'(act_code), int'({10'h0CC, 10'h155, 10'h005, 10'h0AA}));
    chk("R10 bad cmd ext", int'(ext_ref), 1);
    send(3, 5, 'h2FF);
    send(4, 7, 0);
    send(2, 4, 'h111);
    send(1, 12, 0);
    chk("R10 bad addr codes", int'(act_code), int'({10'h0CC, 10'h155, 10'h005, 10'h0AA}));
    chk("R10 bad addr pd", int'(pd), 'b0010);

    // R1 wrong bit counts and sclk while deselected
    send_bits({8'b0, frm(3, 0, 'h3C3)} >> 1, 23);
    chk("R1 short frame", code_of(0), 'h0AA);
    send_bits({7'b0, frm(3, 0, 'h3C3), 1'b0}, 25);
    chk("R1 long frame", code_of(0), 'h0AA);
    for (int i = 0; i < 24; i++) begin
      mosi = 1'b1; sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    end
    chk("R1 sclk while deselected", code_of(0), 'h0AA);
    send(3, 0, 'h3C3);
    chk("R1 exact frame", code_of(0), 'h3C3);
    chk("R1 pd after exact", int'(pd), 'b0010);

    wait_clk(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule